// File: doc/BRIEF.md
# Multi-lane drive level adjuster

This block turns the per-lane drive change requests from a serial display link receiver into one transmit setting for the whole link. The lanes below the active lane count take part. The block uses the largest voltage-swing request and the largest pre-emphasis request among them. It clamps both values against the capabilities of the transmitter that feeds the hop being trained, and it marks which limits were hit.

The result is a lane-set byte. The block copies this byte to all four lane outputs, so every lane is driven at the worst-case level. The limits can come from two places. When the hop is fed straight from the source, they come from source inputs. Otherwise they come from two capability bits of the repeater one step upstream.

A load strobe captures a new setting. A training-clear pulse zeroes the outputs at the start of a new training attempt.

Top module: `drive_level_adjuster`

## Requirements
- R1: Only lanes with index below `lane_cnt` contribute. The chosen swing is the largest of their 2-bit swing requests, and the chosen pre-emphasis is the largest of their 2-bit pre-emphasis requests. With `lane_cnt` of 0 both are 0. Requests of inactive lanes have no effect on the outputs.
- R2: If the chosen pre-emphasis is greater than or equal to the pre-emphasis limit, it is replaced by the limit and the max-pre-emphasis flag (bit 5) is set. Otherwise bit 5 is clear.
- R3: Once pre-emphasis is settled, swing is capped at 3 minus the pre-emphasis level (pre-emphasis 0, 1, 2, 3 permit swing 3, 2, 1, 0).
- R4: If the capped swing is greater than or equal to the swing limit, it is replaced by the limit and the max-swing flag (bit 2) is set. Otherwise bit 2 is clear.
- R5: All four lane-set outputs carry the same byte, whatever the lane count.
- R6: With `hop_from_src` high, the limits are `src_swing_max` and `src_pe_max`. With it low, each limit is 3 if the matching upstream repeater support bit is set, and 2 if it is not.
- R7: `all_max_swing` is high exactly when at least one lane is active and every active lane's stored byte has bit 2 set.
- R8: Outputs change only at a clock edge. `train_clr` clears the bytes and the stored lane count to zero and takes priority over `load`. `load` captures the new setting and the lane count. With neither asserted, the outputs hold. An asynchronous active-low reset clears everything.
- R9: Byte layout: bits 1:0 hold swing, bit 2 is max-swing, bits 4:3 hold pre-emphasis, bit 5 is max-pre-emphasis, and bits 7:6 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_clr | input | 1 | Clears the stored setting (takes priority over load) |
| load | input | 1 | Captures the combined setting |
| lane_cnt | input | 3 | Number of active lanes (0 to 4) |
| swing_req | input | 8 | Swing requests, lane i in bits 2i+1:2i |
| pe_req | input | 8 | Pre-emphasis requests, lane i in bits 2i+1:2i |
| hop_from_src | input | 1 | Hop being trained is fed directly by the source |
| src_swing_max | input | 2 | Source swing limit |
| src_pe_max | input | 2 | Source pre-emphasis limit |
| rpt_swing3_ok | input | 1 | Upstream repeater supports swing level 3 |
| rpt_pe3_ok | input | 1 | Upstream repeater supports pre-emphasis level 3 |
| lane_set0 | output | 8 | Lane 0 setting byte |
| lane_set1 | output | 8 | Lane 1 setting byte |
| lane_set2 | output | 8 | Lane 2 setting byte |
| lane_set3 | output | 8 | Lane 3 setting byte |
| all_max_swing | output | 1 | Every active lane has reached maximum swing |

## Verification
The hardest condition to reach is the max-swing flag while pre-emphasis is nonzero. The pre-emphasis cap pulls swing below any limit of 2 or 3 unless pre-emphasis is 0 or 1. So `all_max_swing` rises only when the request has low pre-emphasis and a high swing, or when a source limit sits below the cap. The stimulus mixes many random cycles, with source limits drawn down to 0, together with directed cases that set a small source swing limit under high pre-emphasis. These cases also load with inactive lanes holding maximum requests, and they pulse the clear at the same time as a load.

// File: rtl/drive_level_adjuster.sv
module drive_level_adjuster #(
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               train_clr,
  input  logic               load,
  input  logic [CW-1:0]      lane_cnt,
  input  logic [2*LANES-1:0] swing_req,
  input  logic [2*LANES-1:0] pe_req,
  input  logic               hop_from_src,
  input  logic [1:0]         src_swing_max,
  input  logic [1:0]         src_pe_max,
  input  logic               rpt_swing3_ok,
  input  logic               rpt_pe3_ok,
  output logic [7:0]         lane_set0,
  output logic [7:0]         lane_set1,
  output logic [7:0]         lane_set2,
  output logic [7:0]         lane_set3,
  output logic               all_max_swing
);

  logic [1:0]    sw_lim, pe_lim, v, p;
  logic          vf, pf;
  logic [7:0]    set_d, set_q;
  logic [CW-1:0] cnt_q;

  assign sw_lim = hop_from_src ? src_swing_max : (rpt_swing3_ok ? 2'd3 : 2'd2);
  assign pe_lim = hop_from_src ? src_pe_max    : (rpt_pe3_ok    ? 2'd3 : 2'd2);

  always_comb begin
    v = '0;
    p = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(lane_cnt)) begin
        if (swing_req[2*i +: 2] > v) v = swing_req[2*i +: 2];
        if (pe_req[2*i +: 2] > p)    p = pe_req[2*i +: 2];
      end
    end
    pf = (p >= pe_lim);
    if (pf) p = pe_lim;
    if (v > 2'd3 - p) v = 2'd3 - p;
    vf = (v >= sw_lim);
    if (vf) v = sw_lim;
    set_d = {2'b00, pf, p, vf, v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      cnt_q <= '0;
    end else if (train_clr) begin
      set_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      set_q <= set_d;
      cnt_q <= lane_cnt;
    end
  end

  assign lane_set0     = set_q;
  assign lane_set1     = set_q;
  assign lane_set2     = set_q;
  assign lane_set3     = set_q;
  assign all_max_swing = (cnt_q != '0) && set_q[2];

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    train_clr |=> (lane_set0 == 8'h00 && !all_max_swing));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!train_clr && !load) |=> ($stable(lane_set0) && $stable(all_max_swing)));
  p_same_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_set0 == lane_set1 && lane_set1 == lane_set2 && lane_set2 == lane_set3));
  p_swing_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, lane_set0[1:0]} + {1'b0, lane_set0[4:3]}) <= 3'd3);
  p_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lane_set0[7:6] == 2'b00);
  p_allmax_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    all_max_swing |-> lane_set0[2]);
  p_rpt_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !train_clr && !hop_from_src && !rpt_swing3_ok) |=> (lane_set0[1:0] <= 2'd2));

endmodule

// File: tb/tb_drive_level_adjuster.sv
module tb_drive_level_adjuster;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       train_clr = 1'b0, load = 1'b0;
  logic [2:0] lane_cnt = 3'd0;
  logic [7:0] swing_req = 8'h00, pe_req = 8'h00;
  logic       hop_from_src = 1'b1;
  logic [1:0] src_swing_max = 2'd3, src_pe_max = 2'd3;
  logic       rpt_swing3_ok = 1'b0, rpt_pe3_ok = 1'b0;
  logic [7:0] lane_set0, lane_set1, lane_set2, lane_set3;
  logic       all_max_swing;

  int checks = 0, failures = 0;
  logic [7:0] exp_byte;
  int exp_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_level_adjuster dut (
    .clk(clk), .rst_n(rst_n), .train_clr(train_clr), .load(load),
    .lane_cnt(lane_cnt), .swing_req(swing_req), .pe_req(pe_req),
    .hop_from_src(hop_from_src), .src_swing_max(src_swing_max),
    .src_pe_max(src_pe_max), .rpt_swing3_ok(rpt_swing3_ok),
    .rpt_pe3_ok(rpt_pe3_ok), .lane_set0(lane_set0), .lane_set1(lane_set1),
    .lane_set2(lane_set2), .lane_set3(lane_set3), .all_max_swing(all_max_swing)
  );

  function automatic logic [7:0] model(int cnt, logic [7:0] sw, logic [7:0] pe, bit src,
                                       int ssm, int spm, bit r3s, bit r3p);
    int v = 0, p = 0, vl, pl;
    bit vf, pf;
    for (int i = 0; i < 4; i++)
      if (i < cnt) begin
        if (int'(sw[2*i +: 2]) > v) v = int'(sw[2*i +: 2]);
        if (int'(pe[2*i +: 2]) > p) p = int'(pe[2*i +: 2]);
      end
    vl = src ? ssm : (r3s ? 3 : 2);
    pl = src ? spm : (r3p ? 3 : 2);
    pf = (p >= pl);
    if (pf) p = pl;
    if (v > 3 - p) v = 3 - p;
    vf = (v >= vl);
    if (vf) v = vl;
    return {2'b00, pf, 2'(p), vf, 2'(v)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_byte <= 8'h00;
      exp_cnt  <= 0;
    end else if (train_clr) begin
      exp_byte <= 8'h00;
      exp_cnt  <= 0;
    end else if (load) begin
      exp_byte <= model(int'(lane_cnt), swing_req, pe_req, hop_from_src,
                        int'(src_swing_max), int'(src_pe_max), rpt_swing3_ok, rpt_pe3_ok);
      exp_cnt  <= int'(lane_cnt);
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 swing field", int'(lane_set0[1:0]), int'(exp_byte[1:0]));
    chk("R4 max-swing flag", int'(lane_set0[2]), int'(exp_byte[2]));
    chk("R1 pre-emphasis field", int'(lane_set0[4:3]), int'(exp_byte[4:3]));
    chk("R2 max-pre-emphasis flag", int'(lane_set0[5]), int'(exp_byte[5]));
    chk("R9 upper bits", int'(lane_set0[7:6]), 0);
    chk("R5 lane1", int'(lane_set1), int'(exp_byte));
    chk("R5 lane2", int'(lane_set2), int'(exp_byte));
    chk("R5 lane3", int'(lane_set3), int'(exp_byte));
    chk("R7 all_max_swing", int'(all_max_swing), int'(exp_cnt != 0 && exp_byte[2]));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic setup(int cnt, logic [7:0] sw, logic [7:0] pe, bit src,
                       int ssm, int spm, bit r3s, bit r3p);
    lane_cnt = 3'(cnt); swing_req = sw; pe_req = pe; hop_from_src = src;
    src_swing_max = 2'(ssm); src_pe_max = 2'(spm);
    rpt_swing3_ok = r3s; rpt_pe3_ok = r3p;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare_all();
    chk("R8 reset byte", int'(lane_set0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: inactive lanes carry maximum requests, one active lane asks for nothing
    setup(1, 8'hFC, 8'hFC, 1'b1, 3, 3, 1'b0, 1'b0); load = 1'b1; step();
    chk("R1 inactive lanes ignored", int'(lane_set0), 8'h00);
    // R1/R3: the maximum over two lanes, swing capped by pre-emphasis 1
    setup(2, 8'b0000_1101, 8'b0000_0100, 1'b1, 3, 3, 1'b0, 1'b0); step();
    chk("R1 two-lane max", int'(lane_set0), {2'b00, 1'b0, 2'd1, 1'b0, 2'd2});
    // R2/R4/R6: repeater hop without level-3 support, requests at 3 and 0
    setup(4, 8'h03, 8'hC0, 1'b0, 0, 0, 1'b0, 1'b0); step();
    chk("R6 repeater limits", int'(lane_set0), {2'b00, 1'b1, 2'd2, 1'b0, 2'd1});
    // R6: repeater with level-3 support, swing 3 reaches its limit
    setup(4, 8'h03, 8'h00, 1'b0, 0, 0, 1'b1, 1'b1); step();
    chk("R6 repeater level 3", int'(lane_set0), {2'b00, 1'b0, 2'd0, 1'b1, 2'd3});
    chk("R7 all max swing high", int'(all_max_swing), 1);
    // R4: a source swing limit of 1 under pre-emphasis 2
    setup(4, 8'hFF, 8'h02, 1'b1, 1, 3, 1'b0, 1'b0); step();
    chk("R4 source clamp", int'(lane_set0), {2'b00, 1'b0, 2'd2, 1'b1, 2'd1});
    // R8: a clear together with a load wins, then the outputs hold
    train_clr = 1'b1; step();
    chk("R8 clear priority", int'(lane_set0), 0);
    train_clr = 1'b0; load = 1'b0; setup(4, 8'hFF, 8'h00, 1'b1, 3, 3, 1'b0, 1'b0); step();
    chk("R8 hold without load", int'(lane_set0), 0);
    // R7: lane count 0 stored
    load = 1'b1; setup(0, 8'hFF, 8'hFF, 1'b1, 0, 0, 1'b0, 1'b0); step();
    chk("R7 zero lanes", int'(all_max_swing), 0);

    for (int n = 0; n < 4000; n++) begin
      load = ($urandom % 10) < 7;
      train_clr = ($urandom % 20) == 0;
      setup(int'($urandom % 5), 8'($urandom), 8'($urandom), 1'($urandom),
            int'($urandom % 4), int'($urandom % 4), 1'($urandom), 1'($urandom));
      if (n == 2000) begin
        rst_n = 1'b0;
        #1;
        rst_n = 1'b1;
      end
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule